// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide, software-facing register set of a legacy-style serial port. A processor reaches it through an 8-byte memory-mapped window, one byte per access. It stores the interrupt-enable, line-control and modem-control bytes and the two divisor bytes. It reports the line status and the pending interrupt cause. Received bytes come in on a valid/ready stream. Bytes written for transmission leave as a one-cycle strobe with the data byte. Bit-level serialisation, baud generation, FIFOs and modem lines are not part of this block.

There are two interrupt causes, receive-data and transmit-empty. Each one is raised through its own restartable delay timer of `DELAY_CYC` clock cycles. A saturating age counter tracks the cycles since the last transmit interrupt. An interrupt-enable write that turns on the transmit cause raises it at once when that age exceeds the delay. Otherwise the write starts the transmit timer. The single interrupt output is high while either cause is pending.

Top module: `serial_regif`

## Requirements
- R1: After reset the interrupt-enable, line-control, modem-control and both divisor bytes read 0. `irq` is low, `tx_strobe` is low, the identification register (offset 2) reads 0x01 and, with no received byte waiting, the line status (offset 5) reads 0x60.
- R2: A read of offset 0 while line-control bit 7 is 0 returns `rx_data` and asserts `rx_ready` in that cycle, or returns 0 when `rx_valid` is low. It clears the RX pending bit at that edge. If the RX enable (interrupt-enable bit 0) is set and `rx_valid` is high in the cycle after the read, the RX timer restarts at the following edge.
- R3: A write to offset 0 while line-control bit 7 is 0 makes `tx_strobe` high with `tx_byte` equal to the written byte for exactly the one cycle after the write edge. It clears the TX pending bit and, when the TX enable (interrupt-enable bit 1) is set, starts the TX timer.
- R4: Offset 2 reads 0x04 while RX is pending, else 0x02 while TX is pending, else 0x01. Only a read that returns 0x02 clears the TX pending bit.
- R5: Offset 5 always reads bits 6 and 5 as 1. Bit 0 equals `rx_valid`. All other bits are 0.
- R6: A cause's pending bit rises exactly `DELAY_CYC` edges after the edge that arms its timer. Arming a running timer restarts the full delay. A timer that expires while its enable is clear sets nothing.
- R7: An interrupt-enable write with bit 1 set raises TX pending at that same edge when more than `DELAY_CYC` cycles have passed since the last TX raise, or since reset. Otherwise it starts the TX timer.
- R8: An interrupt-enable write that clears an enable cancels that cause's timer and clears its pending bit at that edge. A write that sets bit 0 while `rx_valid` is high starts the RX timer. With `rx_valid` low, it leaves RX idle.
- R9: While line-control bit 7 is 1, offsets 0 and 1 read and write the two divisor bytes. Such accesses never assert `rx_ready` or `tx_strobe`.
- R10: `irq` is high exactly while either the RX or the TX pending bit is set.
- R11: Line-control and modem-control read back all 8 written bits. The interrupt-enable register keeps bits 3:0 and reads bits 7:4 as 0. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | A received byte is waiting |
| rx_data | input | 8 | Waiting received byte |
| rx_ready | output | 1 | Received byte consumed this cycle |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples `bus_rdata` and `rx_ready` inside the access cycle, before the edge. Side effects of that access appear just after the edge: cleared or immediately raised pending bits, and `tx_strobe` together with `tx_byte`. The bench checks them 1 ns after the edge. For a timer-driven cause, the bench counts edges from the arming edge to the first cycle in which `irq` is high. It expects `DELAY_CYC`, or `DELAY_CYC`+1 for the RX restart, which is decided one cycle after the read. Ageing cases are placed a known number of cycles after the last TX raise, so each one falls clearly on the immediate side or the timer side of the threshold.

// File: rtl/serial_regif_pkg.sv
`timescale 1ns/1ps
package serial_regif_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned NUM_CAUSES = 2;
  localparam int unsigned CAUSE_RX   = 0;
  localparam int unsigned CAUSE_TX   = 1;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA = 3'd0,
    OFS_IER  = 3'd1,
    OFS_IIR  = 3'd2,
    OFS_LCR  = 3'd3,
    OFS_MCR  = 3'd4,
    OFS_LSR  = 3'd5,
    OFS_MSR  = 3'd6,
    OFS_SPR  = 3'd7
  } reg_ofs_e;

  localparam int unsigned IER_RX_BIT   = 0;
  localparam int unsigned IER_TX_BIT   = 1;
  localparam int unsigned LCR_DIV_BIT  = 7;

  localparam logic [DATA_W-1:0] IIR_NONE = 8'h01;
  localparam logic [DATA_W-1:0] IIR_TX   = 8'h02;
  localparam logic [DATA_W-1:0] IIR_RX   = 8'h04;
  localparam logic [DATA_W-1:0] LSR_IDLE = 8'h60;

  // identification code: receive cause outranks transmit cause
  function automatic logic [DATA_W-1:0] iir_code(input logic rx_p, input logic tx_p);
    if (rx_p)      return IIR_RX;
    else if (tx_p) return IIR_TX;
    else           return IIR_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] lsr_code(input logic data_ready);
    return LSR_IDLE | {{(DATA_W-1){1'b0}}, data_ready};
  endfunction

  // pending update: clear wins over set in the same cycle
  function automatic logic [NUM_CAUSES-1:0] pend_next(input logic [NUM_CAUSES-1:0] cur,
                                                      input logic [NUM_CAUSES-1:0] set,
                                                      input logic [NUM_CAUSES-1:0] clr);
    return (cur | set) & ~clr;
  endfunction

  // down-counter step: cancel beats arm, arm reloads the full delay
  function automatic int unsigned timer_next(input int unsigned cur, input logic arm,
                                             input logic cancel, input int unsigned load);
    if (cancel)        return 0;
    else if (arm)      return load;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

  function automatic int unsigned sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction
endpackage

// File: rtl/sr_delay_timer.sv
`timescale 1ns/1ps
module sr_delay_timer
  import serial_regif_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic cancel,
  output logic fire
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  // last counting cycle; an arm or cancel in that cycle overrides it
  assign fire = (cnt_q == CNT_W'(1)) && !arm && !cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= CNT_W'(timer_next(32'(cnt_q), arm, cancel, DELAY_CYC));
  end
endmodule

// File: rtl/sr_age_counter.sv
`timescale 1ns/1ps
module sr_age_counter
  import serial_regif_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic stale
);
  localparam int unsigned AGE_MAX = DELAY_CYC + 1;
  localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);

  logic [AGE_W-1:0] age_q;

  // saturated means more than DELAY_CYC cycles since the last raise
  assign stale = (age_q == AGE_W'(AGE_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n)       age_q <= AGE_W'(AGE_MAX);
    else if (restart) age_q <= '0;
    else              age_q <= AGE_W'(sat_inc(32'(age_q), AGE_MAX));
  end
endmodule

// File: rtl/sr_reg_bank.sv
`timescale 1ns/1ps
module sr_reg_bank
  import serial_regif_pkg::*;
#(
  parameter int unsigned IER_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_pend,
  input  logic              tx_pend,
  output logic [DATA_W-1:0] rdata,
  output logic              data_rd,
  output logic              data_wr,
  output logic              ier_wr,
  output logic              iir_rd,
  output logic [DATA_W-1:0] ier_q,
  output logic              dlab
);
  logic [IER_BITS-1:0] ier_r;
  logic [DATA_W-1:0]   lcr_r, mcr_r, div_lo_r, div_hi_r;
  logic                acc_rd, acc_wr;

  assign acc_rd  = bus_sel && !bus_wr;
  assign acc_wr  = bus_sel &&  bus_wr;
  assign dlab    = lcr_r[LCR_DIV_BIT];
  assign ier_q   = DATA_W'(ier_r);

  assign data_rd = acc_rd && (bus_addr == OFS_DATA) && !dlab;
  assign data_wr = acc_wr && (bus_addr == OFS_DATA) && !dlab;
  assign ier_wr  = acc_wr && (bus_addr == OFS_IER)  && !dlab;
  assign iir_rd  = acc_rd && (bus_addr == OFS_IIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_r    <= '0;
      lcr_r    <= '0;
      mcr_r    <= '0;
      div_lo_r <= '0;
      div_hi_r <= '0;
    end else if (acc_wr) begin
      case (bus_addr)
        OFS_DATA: if (dlab) div_lo_r <= bus_wdata;
        OFS_IER:  if (dlab) div_hi_r <= bus_wdata;
                  else      ier_r    <= bus_wdata[IER_BITS-1:0];
        OFS_LCR:  lcr_r <= bus_wdata;
        OFS_MCR:  mcr_r <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (bus_addr)
      OFS_DATA: rdata = dlab ? div_lo_r : (rx_valid ? rx_data : '0);
      OFS_IER:  rdata = dlab ? div_hi_r : ier_q;
      OFS_IIR:  rdata = iir_code(rx_pend, tx_pend);
      OFS_LCR:  rdata = lcr_r;
      OFS_MCR:  rdata = mcr_r;
      OFS_LSR:  rdata = lsr_code(rx_valid);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/serial_regif.sv
`timescale 1ns/1ps
module serial_regif
  import serial_regif_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 22,
  parameter int unsigned IER_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_strobe,
  output logic [7:0]  tx_byte,
  output logic        irq
);
  logic                  data_rd, data_wr, ier_wr, iir_rd, dlab;
  logic [DATA_W-1:0]     ier_q;
  logic [NUM_CAUSES-1:0] pend_q, pend_set, pend_clr;
  logic [NUM_CAUSES-1:0] tmr_arm, tmr_cancel, tmr_fire;
  logic                  rx_pend, tx_pend, rx_fire, tx_fire;
  logic                  ier_rx_en, ier_tx_en, wr_rx_en, wr_tx_en;
  logic                  age_stale, tx_now, tx_raise, iir_tx_rd, pop_q;
  logic                  tx_strobe_q;
  logic [DATA_W-1:0]     tx_byte_q;

  sr_reg_bank #(.IER_BITS(IER_BITS)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pend(rx_pend), .tx_pend(tx_pend),
    .rdata(bus_rdata), .data_rd(data_rd), .data_wr(data_wr), .ier_wr(ier_wr),
    .iir_rd(iir_rd), .ier_q(ier_q), .dlab(dlab)
  );

  // named events
  assign rx_pend   = pend_q[CAUSE_RX];
  assign tx_pend   = pend_q[CAUSE_TX];
  assign rx_fire   = tmr_fire[CAUSE_RX];
  assign tx_fire   = tmr_fire[CAUSE_TX];
  assign ier_rx_en = ier_q[IER_RX_BIT];
  assign ier_tx_en = ier_q[IER_TX_BIT];
  assign wr_rx_en  = bus_wdata[IER_RX_BIT];
  assign wr_tx_en  = bus_wdata[IER_TX_BIT];
  assign iir_tx_rd = iir_rd && (iir_code(rx_pend, tx_pend) == IIR_TX);
  assign tx_now    = ier_wr && wr_tx_en && age_stale;

  // timer control
  assign tmr_arm[CAUSE_TX]    = (ier_wr && wr_tx_en && !age_stale) || (data_wr && ier_tx_en);
  assign tmr_cancel[CAUSE_TX] = ier_wr && !wr_tx_en;
  assign tmr_arm[CAUSE_RX]    = (ier_wr && wr_rx_en && rx_valid) ||
                                (pop_q && !ier_wr && ier_rx_en && rx_valid);
  assign tmr_cancel[CAUSE_RX] = ier_wr && !(wr_rx_en && rx_valid);

  for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause_timer
    sr_delay_timer #(.DELAY_CYC(DELAY_CYC)) i_tmr (
      .clk(clk), .rst_n(rst_n),
      .arm(tmr_arm[c]), .cancel(tmr_cancel[c]), .fire(tmr_fire[c])
    );
  end

  // pending bits
  assign pend_set[CAUSE_RX] = rx_fire && ier_rx_en;
  assign pend_set[CAUSE_TX] = (tx_fire && ier_tx_en) || tx_now;
  assign pend_clr[CAUSE_RX] = data_rd || tmr_cancel[CAUSE_RX];
  assign pend_clr[CAUSE_TX] = data_wr || iir_tx_rd || tmr_cancel[CAUSE_TX];
  assign tx_raise           = pend_set[CAUSE_TX] && !pend_clr[CAUSE_TX];

  sr_age_counter #(.DELAY_CYC(DELAY_CYC)) i_age (
    .clk(clk), .rst_n(rst_n), .restart(tx_raise), .stale(age_stale)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= '0;
      pop_q       <= 1'b0;
      tx_strobe_q <= 1'b0;
      tx_byte_q   <= '0;
    end else begin
      pend_q      <= pend_next(pend_q, pend_set, pend_clr);
      pop_q       <= data_rd;
      tx_strobe_q <= data_wr;
      if (data_wr) tx_byte_q <= bus_wdata;
    end
  end

  assign rx_ready  = data_rd;
  assign tx_strobe = tx_strobe_q;
  assign tx_byte   = tx_byte_q;
  assign irq       = |pend_q;
endmodule

// File: rtl/sr_checker.sv
`timescale 1ns/1ps
module sr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_strobe,
  input logic [7:0] tx_byte,
  input logic       irq,
  input logic       dlab,
  input logic       rx_pend,
  input logic       tx_pend,
  input logic       rx_fire,
  input logic       ier_rx_en
);
  a_r3_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd0 && !dlab) |=> (tx_strobe && tx_byte == $past(bus_wdata)));

  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_strobe && !(bus_sel && bus_wr && bus_addr == 3'd0 && !dlab)) |=> !tx_strobe);

  a_r9_div_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd0 && dlab) |=> !tx_strobe);

  a_r2_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_sel && !bus_wr && bus_addr == 3'd0 && !dlab));

  a_r4_tx_report_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd2 && bus_rdata == 8'h02) |=> !tx_pend);

  a_r4_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd2 && rx_pend) |-> bus_rdata == 8'h04);

  a_r5_line_status: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3'd5) |-> (bus_rdata == {1'b0, 2'b11, 4'b0000, rx_valid}));

  a_r8_disable_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd1 && !dlab && !bus_wdata[1]) |=> !tx_pend);

  a_r6_no_raise_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !ier_rx_en && !rx_pend) |=> !rx_pend);

  a_r10_irq_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_pend && !tx_pend) |-> !irq);
endmodule

bind serial_regif sr_checker i_sr_checker (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq), .dlab(dlab),
  .rx_pend(rx_pend), .tx_pend(tx_pend), .rx_fire(rx_fire), .ier_rx_en(ier_rx_en)
);

// File: tb/test_serial_regif.sv
`timescale 1ns/1ps
module test_serial_regif;
  localparam int DLY = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bsel = 1'b0, bwr = 1'b0;
  logic [2:0] baddr = '0;
  logic [7:0] bwdata = '0;
  logic [7:0] bus_rdata;
  logic       rxv = 1'b0;
  logic [7:0] rxd = '0;
  logic       rx_ready, tx_strobe, irq;
  logic [7:0] tx_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  serial_regif #(.DELAY_CYC(DLY)) i_serial_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr), .bus_addr(baddr),
    .bus_wdata(bwdata), .bus_rdata(bus_rdata), .rx_valid(rxv), .rx_data(rxd),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d, output logic rdy);
    @(negedge clk);
    bsel = 1'b1; bwr = 1'b0; baddr = a;
    #1;
    d = bus_rdata; rdy = rx_ready;
    @(posedge clk); #1;
    bsel = 1'b0;
  endtask

  task automatic bus_wt(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = v;
    @(posedge clk); #1;
    bsel = 1'b0; bwr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // edges from the last access edge until irq is first seen high
  task automatic irq_delay(output int k);
    k = 0;
    for (int i = 1; i <= DLY + 4 && k == 0; i++) begin
      @(posedge clk); #1;
      if (irq) k = i;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-reqs act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       r;
    int         k;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tx_strobe", tx_strobe, 0);
    bus_rd(3'd1, d, r); chk("R1 ier", d, 8'h00);
    bus_rd(3'd3, d, r); chk("R1 lcr", d, 8'h00);
    bus_rd(3'd4, d, r); chk("R1 mcr", d, 8'h00);
    bus_rd(3'd2, d, r); chk("R1 iir", d, 8'h01);
    bus_rd(3'd5, d, r); chk("R1 lsr", d, 8'h60);
    bus_rd(3'd0, d, r); chk("R2 empty read", d, 8'h00);
    bus_wt(3'd3, 8'h80);
    bus_rd(3'd0, d, r); chk("R1 div lo", d, 8'h00);
    bus_rd(3'd1, d, r); chk("R1 div hi", d, 8'h00);
    bus_wt(3'd3, 8'h00);

    // R11 readback sweeps
    for (int v = 0; v < 256; v++) begin
      bus_wt(3'd3, 8'(v)); bus_rd(3'd3, d, r); chk("R11 lcr", d, 32'(v));
      bus_wt(3'd4, 8'(v)); bus_rd(3'd4, d, r); chk("R11 mcr", d, 32'(v));
    end
    bus_wt(3'd3, 8'h00);
    for (int v = 0; v < 256; v++) begin
      bus_wt(3'd1, 8'(v) & 8'hFC); bus_rd(3'd1, d, r); chk("R11 ier", d, 32'(v & 8'h0C));
    end
    bus_wt(3'd1, 8'h00);
    bus_rd(3'd6, d, r); chk("R11 ofs6", d, 0);
    bus_rd(3'd7, d, r); chk("R11 ofs7", d, 0);

    // R9 divisor access
    bus_wt(3'd3, 8'h83);
    bus_wt(3'd0, 8'h12); chk("R9 no strobe lo", tx_strobe, 0);
    bus_wt(3'd1, 8'h34); chk("R9 no strobe hi", tx_strobe, 0);
    rxv = 1'b1; rxd = 8'h99;
    bus_rd(3'd0, d, r); chk("R9 div lo", d, 8'h12); chk("R9 no ready", r, 0);
    bus_rd(3'd1, d, r); chk("R9 div hi", d, 8'h34);
    rxv = 1'b0;
    bus_wt(3'd3, 8'h03);
    bus_rd(3'd1, d, r); chk("R9 ier intact", d, 8'h00);

    // R3 transmit sweep, TX enable off
    for (int v = 0; v < 256; v++) begin
      bus_wt(3'd0, 8'(v));
      chk("R3 strobe", tx_strobe, 1); chk("R3 byte", tx_byte, 32'(v));
    end
    idle(1); chk("R3 strobe one cycle", tx_strobe, 0);
    idle(DLY + 2); chk("R3 no timer when disabled", irq, 0);

    // R2 receive sweep, RX enable off
    for (int v = 0; v < 256; v++) begin
      rxv = 1'b1; rxd = 8'(v);
      bus_rd(3'd0, d, r); chk("R2 data", d, 32'(v)); chk("R2 ready", r, 1);
    end
    rxv = 1'b0;
    idle(DLY + 2); chk("R2 no rearm when disabled", irq, 0);

    // R7 immediate raise: no TX raise since reset
    bus_wt(3'd1, 8'h02); chk("R7 immediate", irq, 1);
    bus_rd(3'd2, d, r); chk("R4 tx code", d, 8'h02); chk("R4 tx cleared", irq, 0);
    bus_rd(3'd2, d, r); chk("R4 none code", d, 8'h01);

    // R6 delay from a data write
    bus_wt(3'd0, 8'h55);
    irq_delay(k); chk("R6 tx delay", k, DLY);
    bus_rd(3'd2, d, r); chk("R4 tx code 2", d, 8'h02);
    // R6 restart
    bus_wt(3'd0, 8'h56); idle(2); bus_wt(3'd0, 8'h57);
    irq_delay(k); chk("R6 restart", k, DLY);
    bus_rd(3'd2, d, r);
    // R7 recent raise -> timer
    bus_wt(3'd1, 8'h02); chk("R7 deferred", irq, 0);
    irq_delay(k); chk("R7 timer path", k, DLY);
    bus_rd(3'd2, d, r);
    idle(3 * DLY);
    bus_wt(3'd1, 8'h02); chk("R7 stale immediate", irq, 1);
    bus_rd(3'd2, d, r);

    // R8 cancel
    bus_wt(3'd0, 8'h11); idle(2); bus_wt(3'd1, 8'h00);
    idle(DLY + 3); chk("R8 cancelled timer", irq, 0);
    bus_wt(3'd1, 8'h02); chk("R8 raised again", irq, 1);
    bus_wt(3'd1, 8'h00); chk("R8 disable clears", irq, 0);
    bus_rd(3'd2, d, r); chk("R8 iir none", d, 8'h01);

    // RX path
    bus_wt(3'd1, 8'h01); idle(DLY + 3); chk("R8 rx no data", irq, 0);
    rxv = 1'b1; rxd = 8'hA5;
    bus_wt(3'd1, 8'h01);
    irq_delay(k); chk("R8 rx armed", k, DLY);
    chk("R10 irq rx", irq, 1);
    bus_rd(3'd5, d, r); chk("R5 lsr ready", d, 8'h61);
    bus_rd(3'd2, d, r); chk("R4 rx code", d, 8'h04);
    bus_rd(3'd0, d, r); chk("R2 data A5", d, 8'hA5); chk("R2 ready A5", r, 1);
    rxd = 8'h3C;
    chk("R2 rx cleared", irq, 0);
    irq_delay(k); chk("R2 rearm delay", k, DLY + 1);
    bus_rd(3'd0, d, r); chk("R2 data 3C", d, 8'h3C);
    rxv = 1'b0;
    chk("R2 cleared again", irq, 0);
    idle(DLY + 3); chk("R2 no rearm empty", irq, 0);
    bus_rd(3'd5, d, r); chk("R5 lsr empty", d, 8'h60);

    // R4 priority with both causes
    rxv = 1'b1; rxd = 8'h77;
    idle(3 * DLY);
    bus_wt(3'd1, 8'h03); chk("R7 both tx now", irq, 1);
    idle(DLY + 1);
    bus_rd(3'd2, d, r); chk("R4 rx first", d, 8'h04);
    bus_rd(3'd2, d, r); chk("R4 tx kept", d, 8'h04);
    bus_rd(3'd0, d, r); chk("R2 data 77", d, 8'h77);
    rxv = 1'b0;
    chk("R10 tx still", irq, 1);
    bus_rd(3'd2, d, r); chk("R4 tx second", d, 8'h02);
    bus_rd(3'd2, d, r); chk("R4 none last", d, 8'h01);
    chk("R10 irq low", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule